// File: doc/BRIEF.md
# Addressable Configuration Register Slice

This block is one storage slice on a shared configuration bus. Many slices sit on the same address, data and control lines, and each one holds the setting for a single programmable entity, such as a bias DAC code or a clock-synthesis setting. A slice acts only when the address bus carries its own instance address, which is fixed by a parameter. On that clock edge it applies the operation selected by the 3-bit control code to its stored word. The stored word drives the configured entity through a dedicated output at all times.

The stored word may be narrower than the 8-bit data bus; for example, a 4-bit slice suits an entity that needs only a few bits. A parameter mask says which control codes a slice supports, and a slice ignores any code it does not support. A read puts the stored word onto a read-back bus one cycle later and raises a valid flag. At all other times the read-back bus is zero, so the read-back buses of all slices on the bus can be OR-combined.

Top module: `cfg_slice`

## Requirements
- R1: When the address bus differs from the instance address, the stored word does not change, the read-back bus stays zero and the valid flag stays low, whatever the control code.
- R2: Control code 010 (write) with a matching address loads the low REG_W bits of the data bus into the stored word. Higher data bits are ignored.
- R3: Control code 001 (read) with a matching address gives, one cycle later, the stored word as it was before that edge, zero-extended to 8 bits, with the valid flag high. In every other cycle the read-back bus is zero and the valid flag is low.
- R4: Control code 011 (set) loads all ones, and code 100 (clear) loads all zeros, without regard to the data bus.
- R5: Control code 101 adds one to the stored word and code 110 subtracts one, both modulo 2^REG_W, so all ones plus one gives zero.
- R6: Control code 000 (shift toward the LSB) moves data-bus bit 0 into the MSB and drops the old LSB.
- R7: Control code 111 (shift toward the MSB) moves data-bus bit 0 into the LSB and drops the old MSB.
- R8: Bit k of the OP_MASK parameter enables control code k. A matching address with a disabled code leaves the stored word unchanged and, for a disabled read, produces no read-back.
- R9: A synchronous active-high reset loads the stored word with RST_VAL and clears the read-back bus and valid flag. Reset takes priority over any bus operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all operations occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Shared address bus |
| bus_ctrl | input | 3 | Shared control code |
| bus_din | input | DATA_W (8) | Shared write data bus |
| rd_data | output | DATA_W (8) | Registered read-back, zero outside a read response |
| rd_valid | output | 1 | High in the cycle after an accepted read |
| cfg_val | output | REG_W | Stored word that drives the configured entity |

## Verification
The hardest cases are those where a request is presented at the ports but must leave no trace. These are a disabled opcode on a matching address, and any opcode on a neighbouring address. In both cases the stored word must stay the same and the read-back bus must stay zero. The stimulus drives each of these cases right after a state change whose value is known. It then reads the slice back, so that an illegal update would show as a wrong value. The bench uses a 4-bit slice with decrement masked off. Increment is driven across the all-ones boundary. Reset is raised in the same cycle as a write, which shows that reset wins.

// File: rtl/cfg_slice_pkg.sv
package cfg_slice_pkg;

  localparam int BUS_ADDR_W = 8;
  localparam int BUS_DATA_W = 8;
  localparam int BUS_CTRL_W = 3;

  typedef enum logic [BUS_CTRL_W-1:0] {
    OP_SHR = 3'd0,
    OP_RD  = 3'd1,
    OP_WR  = 3'd2,
    OP_SET = 3'd3,
    OP_CLR = 3'd4,
    OP_INC = 3'd5,
    OP_DEC = 3'd6,
    OP_SHL = 3'd7
  } cfg_op_e;

endpackage

// File: rtl/cfg_slice_decode.sv
module cfg_slice_decode
  import cfg_slice_pkg::*;
#(
  parameter int                ADDR_W    = BUS_ADDR_W,
  parameter logic [ADDR_W-1:0] INST_ADDR = '0,
  parameter logic [7:0]        OP_MASK   = 8'hFF
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [BUS_CTRL_W-1:0] ctrl,
  output cfg_op_e               op,
  output logic                  upd_en,
  output logic                  rd_en
);

  logic hit;
  logic op_ok;

  assign hit   = (addr == INST_ADDR);
  assign op    = cfg_op_e'(ctrl);
  assign op_ok = hit && OP_MASK[ctrl];

  // reads never modify the stored word
  assign rd_en  = op_ok && (op == OP_RD);
  assign upd_en = op_ok && (op != OP_RD);

endmodule

// File: rtl/cfg_slice_alu.sv
module cfg_slice_alu
  import cfg_slice_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int DATA_W = BUS_DATA_W
) (
  input  cfg_op_e           op,
  input  logic [REG_W-1:0]  cur,
  input  logic [DATA_W-1:0] din,
  output logic [REG_W-1:0]  nxt
);

  always_comb begin
    nxt = cur;
    unique case (op)
      OP_SHR: nxt = {din[0], cur[REG_W-1:1]};
      OP_SHL: nxt = {cur[REG_W-2:0], din[0]};
      OP_WR:  nxt = din[REG_W-1:0];
      OP_SET: nxt = '1;
      OP_CLR: nxt = '0;
      OP_INC: nxt = cur + REG_W'(1);
      OP_DEC: nxt = cur - REG_W'(1);
      OP_RD:  nxt = cur;
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/cfg_slice_readback.sv
module cfg_slice_readback #(
  parameter int REG_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [REG_W-1:0]  cur,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_en ? DATA_W'(cur) : '0;
      rd_valid <= rd_en;
    end
  end

endmodule

// File: rtl/cfg_slice.sv
module cfg_slice
  import cfg_slice_pkg::*;
#(
  parameter int                ADDR_W    = BUS_ADDR_W,
  parameter int                DATA_W    = BUS_DATA_W,
  parameter int                REG_W     = 8,
  parameter logic [ADDR_W-1:0] INST_ADDR = 8'h2A,
  parameter logic [REG_W-1:0]  RST_VAL   = '0,
  parameter logic [7:0]        OP_MASK   = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_CTRL_W-1:0] bus_ctrl,
  input  logic [DATA_W-1:0]     bus_din,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic [REG_W-1:0]      cfg_val
);

  cfg_op_e          op;
  logic             upd_en;
  logic             rd_en;
  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] cfg_nxt;

  cfg_slice_decode #(
    .ADDR_W   (ADDR_W),
    .INST_ADDR(INST_ADDR),
    .OP_MASK  (OP_MASK)
  ) u_dec (
    .addr  (bus_addr),
    .ctrl  (bus_ctrl),
    .op    (op),
    .upd_en(upd_en),
    .rd_en (rd_en)
  );

  cfg_slice_alu #(
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) u_alu (
    .op (op),
    .cur(cfg_q),
    .din(bus_din),
    .nxt(cfg_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= RST_VAL;
    else if (upd_en) cfg_q <= cfg_nxt;
  end

  cfg_slice_readback #(
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) u_rb (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .cur     (cfg_q),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  assign cfg_val = cfg_q;

endmodule

// File: rtl/cfg_slice_chk.sv
module cfg_slice_chk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                REG_W     = 8,
  parameter logic [ADDR_W-1:0] INST_ADDR = '0,
  parameter logic [REG_W-1:0]  RST_VAL   = '0,
  parameter logic [7:0]        OP_MASK   = 8'hFF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_ctrl,
  input logic [DATA_W-1:0] bus_din,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [REG_W-1:0]  cfg_val
);

  logic acc;
  assign acc = (bus_addr == INST_ADDR) && OP_MASK[bus_ctrl];

  assert_miss_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != INST_ADDR) |=> $stable(cfg_val) && !rd_valid);

  assert_write_load_R2: assert property (@(posedge clk) disable iff (rst)
    (acc && bus_ctrl == 3'd2) |=> cfg_val == $past(bus_din[REG_W-1:0]));

  assert_read_resp_R3: assert property (@(posedge clk) disable iff (rst)
    (acc && bus_ctrl == 3'd1) |=> rd_valid && rd_data == DATA_W'($past(cfg_val)));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);

  assert_set_ones_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && bus_ctrl == 3'd3) |=> &cfg_val);

  assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (acc && bus_ctrl == 3'd5) |=> cfg_val == $past(cfg_val) + REG_W'(1));

  assert_masked_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == INST_ADDR && !OP_MASK[bus_ctrl]) |=> $stable(cfg_val) && !rd_valid);

  assert_reset_load_R9: assert property (@(posedge clk)
    rst |=> cfg_val == RST_VAL && !rd_valid && rd_data == '0);

endmodule

bind cfg_slice cfg_slice_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .REG_W    (REG_W),
  .INST_ADDR(INST_ADDR),
  .RST_VAL  (RST_VAL),
  .OP_MASK  (OP_MASK)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_addr(bus_addr),
  .bus_ctrl(bus_ctrl),
  .bus_din (bus_din),
  .rd_data (rd_data),
  .rd_valid(rd_valid),
  .cfg_val (cfg_val)
);

// File: tb/cfg_slice_test.sv
module cfg_slice_test;

  localparam logic [7:0] ADDR = 8'h3C;
  localparam int         W    = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic [2:0] bus_ctrl = 3'd0;
  logic [7:0] bus_din = 8'h00;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [W-1:0] cfg_val;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // 4-bit slice, reset value 5, decrement (code 110) disabled
  cfg_slice #(
    .REG_W    (W),
    .INST_ADDR(ADDR),
    .RST_VAL  (4'h5),
    .OP_MASK  (8'hBF)
  ) uut (
    .clk     (clk),
    .rst     (rst),
    .bus_addr(bus_addr),
    .bus_ctrl(bus_ctrl),
    .bus_din (bus_din),
    .rd_data (rd_data),
    .rd_valid(rd_valid),
    .cfg_val (cfg_val)
  );

  // {addr, ctrl, din, expected cfg, expected rd_data, expected rd_valid}
  localparam int NV = 25;
  localparam logic [31:0] VEC [NV] = '{
    {8'h3C, 3'd1, 8'h00, 4'h5, 8'h05, 1'b1},
    {8'h3C, 3'd2, 8'hFA, 4'hA, 8'h00, 1'b0},
    {8'h3C, 3'd1, 8'h00, 4'hA, 8'h0A, 1'b1},
    {8'h3D, 3'd1, 8'h00, 4'hA, 8'h00, 1'b0},
    {8'h3D, 3'd2, 8'h03, 4'hA, 8'h00, 1'b0},
    {8'h00, 3'd3, 8'h00, 4'hA, 8'h00, 1'b0},
    {8'h3C, 3'd3, 8'h00, 4'hF, 8'h00, 1'b0},
    {8'h3C, 3'd1, 8'h00, 4'hF, 8'h0F, 1'b1},
    {8'h3C, 3'd5, 8'h00, 4'h0, 8'h00, 1'b0},
    {8'h3C, 3'd6, 8'h00, 4'h0, 8'h00, 1'b0},
    {8'h3C, 3'd1, 8'h00, 4'h0, 8'h00, 1'b1},
    {8'h3C, 3'd2, 8'h03, 4'h3, 8'h00, 1'b0},
    {8'h3C, 3'd4, 8'hFF, 4'h0, 8'h00, 1'b0},
    {8'h3C, 3'd2, 8'h09, 4'h9, 8'h00, 1'b0},
    {8'h3C, 3'd0, 8'h01, 4'hC, 8'h00, 1'b0},
    {8'h3C, 3'd7, 8'h00, 4'h8, 8'h00, 1'b0},
    {8'h3C, 3'd0, 8'hFE, 4'h4, 8'h00, 1'b0},
    {8'h3C, 3'd7, 8'h01, 4'h9, 8'h00, 1'b0},
    {8'h3C, 3'd1, 8'h00, 4'h9, 8'h09, 1'b1},
    {8'h3C, 3'd1, 8'h00, 4'h9, 8'h09, 1'b1},
    {8'h3C, 3'd5, 8'h00, 4'hA, 8'h00, 1'b0},
    {8'h3C, 3'd2, 8'h0E, 4'hE, 8'h00, 1'b0},
    {8'h3C, 3'd5, 8'h00, 4'hF, 8'h00, 1'b0},
    {8'h3C, 3'd5, 8'h00, 4'h0, 8'h00, 1'b0},
    {8'h3C, 3'd1, 8'h00, 4'h0, 8'h00, 1'b1}
  };

  function automatic string req_of(input logic [7:0] a, input logic [2:0] c);
    if (a != ADDR) return "R1";
    case (c)
      3'd0: return "R6";
      3'd1: return "R3";
      3'd2: return "R2";
      3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] ec,
                       input logic [7:0] ed, input logic ev);
    tests++;
    if (cfg_val !== ec || rd_data !== ed || rd_valid !== ev) begin
      fails++;
      $display("FAIL %s: cfg=%h data=%h valid=%b expected cfg=%h data=%h valid=%b",
               req, cfg_val, rd_data, rd_valid, ec, ed, ev);
    end
  endtask

  // drive away from the edge, apply on the next rising edge, sample after it
  task automatic step(input logic r, input logic [7:0] a, input logic [2:0] c,
                      input logic [7:0] d);
    rst = r; bus_addr = a; bus_ctrl = c; bus_din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 5000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(1'b1, 8'h00, 3'd0, 8'h00);
    step(1'b1, 8'h00, 3'd0, 8'h00);
    check("R9", 4'h5, 8'h00, 1'b0);   // R9 reset state

    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][31:24], VEC[i][23:21], VEC[i][20:13]);
      check(req_of(VEC[i][31:24], VEC[i][23:21]),
            VEC[i][12:9], VEC[i][8:1], VEC[i][0]);
    end

    // R9: reset in the same cycle as a write and a pending read response
    step(1'b0, ADDR, 3'd1, 8'h00);
    step(1'b1, ADDR, 3'd2, 8'h0A);
    check("R9", 4'h5, 8'h00, 1'b0);
    step(1'b0, ADDR, 3'd1, 8'h00);
    check("R9", 4'h5, 8'h05, 1'b1);
    // R3: valid lasts one cycle, data returns to zero on a miss
    step(1'b0, 8'h3B, 3'd1, 8'h00);
    check("R3", 4'h5, 8'h00, 1'b0);
    // R8: disabled decrement on a nonzero word
    step(1'b0, ADDR, 3'd6, 8'h00);
    check("R8", 4'h5, 8'h00, 1'b0);
    step(1'b0, ADDR, 3'd1, 8'h00);
    check("R8", 4'h5, 8'h05, 1'b1);
    // R2: upper data bits ignored by the 4-bit slice
    step(1'b0, ADDR, 3'd2, 8'hF0);
    check("R2", 4'h0, 8'h00, 1'b0);
    // R4: clear ignores data bus
    step(1'b0, ADDR, 3'd3, 8'h00);
    step(1'b0, ADDR, 3'd4, 8'hFF);
    check("R4", 4'h0, 8'h00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule